// File: doc/BRIEF.md
# Ethernet transmit frame assembler

This block gathers an outgoing Ethernet frame that software writes as a series of 32-bit data words. It then plays the frame out as a byte stream with a valid/ready handshake and an end-of-frame marker. The first word written while the assembler is idle is a length word. Its low half gives the payload length, which excludes the 14-byte Ethernet header. Its upper two bytes are the first two bytes of the frame. Every later word adds four frame bytes.

From the length, the block works out how many bytes to collect. When software supplies the frame check sequence, four extra bytes are collected and then dropped before output. The block can also pad short frames with zeros to the minimum frame size. A length that is too large raises a sticky error flag and the frame is dropped. A completed frame raises a done flag. Acknowledging the error flag throws away whatever the assembler holds and returns it to idle.

While a frame streams out, the write port deasserts its ready signal. Writes offered in that time are not taken.

Top module: `eth_tx_assembler`

## Requirements
- R1: After reset, tx_valid, tx_last, err_flag and done_flag are 0 and wr_ready is 1.
- R2: The first accepted word in idle is the length word. Bits 15:0 hold the payload length, bits 23:16 hold frame byte 0 and bits 31:24 hold frame byte 1. Each later accepted word supplies the next four frame bytes, bits 7:0 first and bits 31:24 last.
- R3: A length above MAX_LEN (2032) sets err_flag in the cycle after the write. No frame is started and the assembler stays idle, so the next accepted word is again a length word. err_flag stays at 1 until it is acknowledged.
- R4: With cfg_sw_fcs=0, collection ends at the first word that brings the collected byte count to at least length+14. The frame sent is length+14 bytes long. Any bytes in the final word beyond that count are discarded.
- R5: With cfg_sw_fcs=1, collection ends at the first word that brings the collected byte count to at least length+18. The trailing four check bytes are dropped, so length+14 bytes are sent.
- R6: With cfg_pad_en=1 and length+14 below 60, the frame is extended to exactly 60 bytes with zero bytes. With cfg_pad_en=0, no padding is added.
- R7: done_flag rises in the cycle after the completing word and stays at 1 until ack_done. tx_last is 1 only on the final byte of the frame.
- R8: From the completing word until the handshake of the final byte, wr_ready is 0 and offered words are ignored. wr_ready returns to 1 in the cycle after that handshake.
- R9: ack_err clears err_flag and, from the next cycle on, drops tx_valid and any partial or streaming frame. The next accepted word is a length word. A word offered in the same cycle as ack_err is ignored.
- R10: While tx_valid is 1 and tx_ready is 0, tx_valid, tx_data and tx_last hold their values.
- R11: cfg_sw_fcs and cfg_pad_en are sampled with the length word. Later changes do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sw_fcs | input | 1 | 1: software writes the four check bytes, which are stripped |
| cfg_pad_en | input | 1 | 1: zero-pad frames shorter than 60 bytes |
| wr_valid | input | 1 | Data word offered |
| wr_data | input | 32 | Data word (length word or four frame bytes) |
| wr_ready | output | 1 | Word accepted when wr_valid and wr_ready are both 1 |
| ack_err | input | 1 | Clear err_flag and return the assembler to idle |
| ack_done | input | 1 | Clear done_flag |
| err_flag | output | 1 | Sticky over-length error |
| done_flag | output | 1 | Sticky frame-complete flag |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of frame |

## Verification
Flags and ready signals change on the clock edge that accepts the causing word or pulse. The bench drives inputs on the falling edge and reads results on the falling edge that follows. Every flag check therefore lands exactly one edge after its stimulus. The first output byte is valid in the cycle right after the completing word. Bytes are counted only when valid and ready are both seen before the accepting edge, so random stalls cannot shift the comparison. The bench checks stalled output for stability on each following falling edge.

// File: rtl/etx_pkg.sv
// Shared types for the transmit frame assembler.
package etx_pkg;
    // Control phase: waiting for a length word, filling, or streaming out.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_SEND = 2'd2
    } etx_state_e;
endpackage

// File: rtl/etx_len_decode.sv
// Length-word decoder.
// Turns the 16-bit length field and the configuration bits into three values:
// the byte count to collect, the count of real data bytes, and the count of
// bytes to emit. Purely combinational; the caller latches the results.
// Assumes MAX_LEN + HDR_BYTES + FCS_BYTES fits in CNT_W bits.
module etx_len_decode #(
    parameter int CNT_W     = 12,
    parameter int MAX_LEN   = 2032,
    parameter int HDR_BYTES = 14,
    parameter int FCS_BYTES = 4,
    parameter int MIN_FRAME = 60
) (
    input  logic [15:0]      len_field,
    input  logic             sw_fcs,
    input  logic             pad_en,
    output logic             too_long,
    output logic [CNT_W-1:0] need_bytes,
    output logic [CNT_W-1:0] data_bytes,
    output logic [CNT_W-1:0] frame_bytes
);
    localparam logic [CNT_W-1:0] HDR_C = CNT_W'(HDR_BYTES);
    localparam logic [CNT_W-1:0] FCS_C = CNT_W'(FCS_BYTES);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_FRAME);

    logic [CNT_W-1:0] len_lo;

    // Derive collect/data/emit sizes from the length field.
    always_comb begin
        too_long    = (len_field > 16'(MAX_LEN));
        len_lo      = len_field[CNT_W-1:0];
        data_bytes  = len_lo + HDR_C;
        need_bytes  = data_bytes + (sw_fcs ? FCS_C : '0);
        frame_bytes = (pad_en && (data_bytes < MIN_C)) ? MIN_C : data_bytes;
    end
endmodule

// File: rtl/etx_word_store.sv
// Frame word buffer.
// Stores accepted words in arrival order. The length word lands in slot 0 and
// its two frame bytes sit in lanes 2 and 3, so frame byte k is found at flat
// byte position k+2. Read is combinational from the byte index.
// Assumes the writer never exceeds WORDS slots.
module etx_word_store #(
    parameter int WORDS = 514,
    parameter int AW    = 10,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [31:0]      wr_word,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    logic [31:0]      mem [WORDS];
    logic [CNT_W-1:0] flat_pos;
    logic [AW-1:0]    rd_slot;
    logic [31:0]      rd_word;

    // Capture an accepted word into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end
    end

    // Map the frame byte index onto a slot and a byte lane.
    always_comb begin
        flat_pos = rd_idx + CNT_W'(2);
        rd_slot  = AW'(flat_pos >> 2);
        rd_word  = mem[rd_slot];
        rd_byte  = rd_word[flat_pos[1:0]*8 +: 8];
    end
endmodule

// File: rtl/etx_stream_out.sv
// Byte streamer.
// Once started, walks the byte index from 0 to frame_bytes-1 under a
// valid/ready handshake. Indices at or past data_bytes produce zero (padding).
// abort drops the stream at once. Assumes frame_bytes >= 1 when started.
module etx_stream_out #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [CNT_W-1:0] frame_bytes,
    input  logic [CNT_W-1:0] data_bytes,
    input  logic [7:0]       mem_byte,
    input  logic             tx_ready,
    output logic [CNT_W-1:0] rd_idx,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic             finished
);
    logic             active;
    logic [CNT_W-1:0] idx;

    // Output byte, end marker and completion pulse for the current index.
    always_comb begin
        rd_idx   = idx;
        tx_valid = active;
        tx_data  = (idx < data_bytes) ? mem_byte : 8'h00;
        tx_last  = active && (idx == frame_bytes - CNT_W'(1));
        finished = tx_last && tx_ready;
    end

    // Advance the index on each handshake; stop after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (abort) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active && tx_ready) begin
            if (tx_last) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/eth_tx_assembler.sv
// Ethernet transmit frame assembler (top).
// Accepts a length word followed by data words, buffers the frame, and then
// streams it out byte by byte. It handles the over-length error, stripping of
// software check bytes, zero padding and the sticky done/error flags.
// Assumes one word per cycle at most and that the stream sink obeys
// valid/ready.
module eth_tx_assembler #(
    parameter int BUF_BYTES = 2048,
    parameter int MAX_LEN   = 2032,
    parameter int HDR_BYTES = 14,
    parameter int FCS_BYTES = 4,
    parameter int MIN_FRAME = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_sw_fcs,
    input  logic        cfg_pad_en,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    output logic        wr_ready,
    input  logic        ack_err,
    input  logic        ack_done,
    output logic        err_flag,
    output logic        done_flag,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_last
);
    import etx_pkg::*;

    localparam int CNT_W = $clog2(BUF_BYTES + 8);
    localparam int WORDS = BUF_BYTES / 4 + 2;
    localparam int AW    = $clog2(WORDS);

    etx_state_e       state;
    logic [CNT_W-1:0] got_bytes;
    logic [CNT_W-1:0] need_q, data_q, frame_q;
    logic [AW-1:0]    wptr;

    logic             too_long;
    logic [CNT_W-1:0] need_d, data_d, frame_d;
    logic             wr_fire, err_set, done_set, complete;
    logic [AW-1:0]    wr_addr;
    logic [CNT_W-1:0] rd_idx;
    logic [7:0]       mem_byte;
    logic             finished;

    etx_len_decode #(
        .CNT_W(CNT_W), .MAX_LEN(MAX_LEN), .HDR_BYTES(HDR_BYTES),
        .FCS_BYTES(FCS_BYTES), .MIN_FRAME(MIN_FRAME)
    ) u_dec (
        .len_field  (wr_data[15:0]),
        .sw_fcs     (cfg_sw_fcs),
        .pad_en     (cfg_pad_en),
        .too_long   (too_long),
        .need_bytes (need_d),
        .data_bytes (data_d),
        .frame_bytes(frame_d)
    );

    // Accept, error and completion decisions for the current cycle.
    always_comb begin
        wr_ready = (state != ST_SEND);
        wr_fire  = wr_valid && wr_ready && !ack_err;
        complete = (got_bytes + CNT_W'(4)) >= need_q;
        err_set  = wr_fire && (state == ST_IDLE) && too_long;
        done_set = wr_fire && (state == ST_FILL) && complete;
        wr_addr  = (state == ST_IDLE) ? '0 : wptr;
    end

    etx_word_store #(.WORDS(WORDS), .AW(AW), .CNT_W(CNT_W)) u_store (
        .clk    (clk),
        .wr_en  (wr_fire && !err_set),
        .wr_addr(wr_addr),
        .wr_word(wr_data),
        .rd_idx (rd_idx),
        .rd_byte(mem_byte)
    );

    etx_stream_out #(.CNT_W(CNT_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (done_set),
        .abort      (ack_err),
        .frame_bytes(frame_q),
        .data_bytes (data_q),
        .mem_byte   (mem_byte),
        .tx_ready   (tx_ready),
        .rd_idx     (rd_idx),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .finished   (finished)
    );

    // Sticky flags: set has priority over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag  <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            err_flag  <= err_set  || (err_flag  && !ack_err);
            done_flag <= done_set || (done_flag && !ack_done);
        end
    end

    // Phase control, byte counting and latching of the decoded sizes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            got_bytes <= '0;
            wptr      <= '0;
            need_q    <= '0;
            data_q    <= '0;
            frame_q   <= '0;
        end else if (ack_err) begin
            state     <= ST_IDLE;
            got_bytes <= '0;
            wptr      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (wr_fire && !too_long) begin
                        need_q    <= need_d;
                        data_q    <= data_d;
                        frame_q   <= frame_d;
                        got_bytes <= CNT_W'(2);
                        wptr      <= AW'(1);
                        state     <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (wr_fire) begin
                        wptr      <= wptr + AW'(1);
                        got_bytes <= got_bytes + CNT_W'(4);
                        if (complete) begin
                            state <= ST_SEND;
                        end
                    end
                end
                ST_SEND: begin
                    if (finished) begin
                        state     <= ST_IDLE;
                        got_bytes <= '0;
                        wptr      <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eth_tx_assembler_chk.sv
// Protocol checker for the transmit frame assembler, bound to every instance.
module eth_tx_assembler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_ready,
    input logic       ack_err,
    input logic       err_flag,
    input logic       done_flag,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       tx_last
);
    assert_send_blocks_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !wr_ready);

    assert_last_within_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_done_at_fill_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_ready) |-> done_flag);

    assert_err_ack_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |=> (!err_flag && !tx_valid && wr_ready));

    assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !ack_err) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_release_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last && !ack_err) |=> (wr_ready && !tx_valid));

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !ack_err) |=> err_flag);
endmodule

bind eth_tx_assembler eth_tx_assembler_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ready (wr_ready),
    .ack_err  (ack_err),
    .err_flag (err_flag),
    .done_flag(done_flag),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last)
);

// File: tb/eth_tx_assembler_test.sv
// Self-checking bench: directed corners plus seeded random frames.
module eth_tx_assembler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sw_fcs = 1'b0, cfg_pad_en = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ack_err = 1'b0, ack_done = 1'b0, tx_ready = 1'b0;
    logic        wr_ready, err_flag, done_flag, tx_valid, tx_last;
    logic [7:0]  tx_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    eth_tx_assembler uut (
        .clk(clk), .rst_n(rst_n), .cfg_sw_fcs(cfg_sw_fcs), .cfg_pad_en(cfg_pad_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .ack_err(ack_err), .ack_done(ack_done), .err_flag(err_flag),
        .done_flag(done_flag), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Offer one word at a falling edge; returns at the falling edge after acceptance.
    task automatic put_word(input logic [31:0] w);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_ack_err();
        ack_err = 1'b1;
        @(negedge clk);
        ack_err = 1'b0;
    endtask

    // Collect bytes under random backpressure until the final byte.
    task automatic collect(input bit junk, ref logic [7:0] got[$]);
        bit          stalled = 1'b0;
        logic [7:0]  held = '0;
        bit          seen_last = 1'b0;
        int          guard = 0;
        while (!seen_last && guard < 20000) begin
            tx_ready = ($urandom_range(0, 3) != 0);
            if (junk) begin
                wr_valid = 1'b1;
                wr_data  = {16'hbeef, 16'd7};
            end
            if (tx_valid && !wr_ready) begin
                // R8 holds here; nothing to report
            end else if (tx_valid) begin
                check(1'b0, "R8 wr_ready while streaming", wr_ready, 0);
            end
            if (stalled)
                check(tx_valid && tx_data == held, "R10 stalled byte changed", tx_data, held);
            stalled = tx_valid && !tx_ready;
            held    = tx_data;
            if (tx_valid && tx_ready) begin
                got.push_back(tx_data);
                if (tx_last) seen_last = 1'b1;
            end
            @(negedge clk);
            guard++;
        end
        wr_valid = 1'b0;
        tx_ready = 1'b0;
    endtask

    // Build, send and check one frame; flip changes cfg after the length word (R11).
    task automatic run_frame(input int len, input bit sw, input bit pad,
                             input bit flip, input bit junk, input string tag);
        logic [7:0] b[$];
        logic [7:0] expq[$];
        logic [7:0] got[$];
        int need;
        int nwords;
        int first_bad;
        need = len + 14 + (sw ? 4 : 0);
        for (int i = 0; i < need; i++) b.push_back(8'($urandom));
        nwords = (need - 2 + 3) / 4;
        cfg_sw_fcs = sw;
        cfg_pad_en = pad;
        put_word({b[1], b[0], 16'(len)});
        if (flip) begin
            cfg_sw_fcs = !sw;
            cfg_pad_en = !pad;
        end
        for (int n = 0; n < nwords; n++) begin
            logic [31:0] w;
            for (int k = 0; k < 4; k++) begin
                int p;
                p = 2 + 4 * n + k;
                w[8*k +: 8] = (p < need) ? b[p] : 8'($urandom);
            end
            put_word(w);
        end
        check(done_flag == 1'b1, {"R7 done after fill ", tag}, done_flag, 1);
        check(wr_ready == 1'b0, {"R8 ready low at send ", tag}, wr_ready, 0);
        for (int i = 0; i < len + 14; i++) expq.push_back(b[i]);
        while (pad && expq.size() < 60) expq.push_back(8'h00);
        collect(junk, got);
        check(got.size() == expq.size(), {"R4 R5 R6 frame length ", tag}, got.size(), expq.size());
        first_bad = -1;
        for (int i = 0; i < got.size() && i < expq.size(); i++)
            if (first_bad < 0 && got[i] !== expq[i]) first_bad = i;
        check(first_bad < 0, {"R2 R6 R11 frame bytes ", tag},
              first_bad < 0 ? 0 : got[first_bad], first_bad < 0 ? 0 : expq[first_bad]);
        check(wr_ready == 1'b1 && tx_valid == 1'b0, {"R8 released after last ", tag}, wr_ready, 1);
        ack_done = 1'b1;
        @(negedge clk);
        ack_done = 1'b0;
        check(done_flag == 1'b0, {"R7 done cleared ", tag}, done_flag, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_valid == 0 && tx_last == 0, "R1 tx idle", tx_valid, 0);
        check(wr_ready == 1, "R1 wr_ready", wr_ready, 1);
        check(err_flag == 0 && done_flag == 0, "R1 flags", {err_flag, done_flag}, 0);

        // Directed corners: R4 R5 R6
        run_frame(0, 0, 0, 0, 0, "len0 plain");
        run_frame(0, 0, 1, 0, 0, "len0 pad");
        run_frame(45, 1, 1, 0, 0, "len45 pad sw");
        run_frame(46, 0, 1, 0, 0, "len46 pad exact");
        run_frame(3, 1, 0, 0, 1, "len3 sw junk");
        run_frame(2032, 1, 0, 0, 0, "max sw");
        run_frame(2032, 0, 1, 0, 0, "max hw");

        // R3 over-length
        put_word({16'h1234, 16'd2033});
        check(err_flag == 1, "R3 err set", err_flag, 1);
        check(wr_ready == 1 && tx_valid == 0, "R3 stays idle", tx_valid, 0);
        run_frame(10, 0, 0, 0, 0, "after overlen");
        check(err_flag == 1, "R3 err sticky", err_flag, 1);
        pulse_ack_err();
        check(err_flag == 0, "R9 err cleared", err_flag, 0);

        // R9 abort mid-fill
        put_word({16'h0, 16'd100});
        put_word(32'h1111_1111);
        put_word(32'h2222_2222);
        pulse_ack_err();
        check(wr_ready == 1 && tx_valid == 0, "R9 idle after abort", wr_ready, 1);
        run_frame(20, 0, 0, 0, 0, "after abort");

        // R9 abort while streaming
        cfg_sw_fcs = 0; cfg_pad_en = 0;
        put_word({16'h0, 16'd2});
        for (int i = 0; i < 4; i++) put_word(32'hcafe_0000 + i);
        check(tx_valid == 1, "R9 stream started", tx_valid, 1);
        pulse_ack_err();
        check(tx_valid == 0 && wr_ready == 1, "R9 stream dropped", tx_valid, 0);
        ack_done = 1'b1; @(negedge clk); ack_done = 1'b0;
        run_frame(7, 1, 0, 0, 0, "after stream abort");

        // R11 config changes after the length word
        run_frame(12, 1, 1, 1, 0, "cfg flip a");
        run_frame(30, 0, 0, 1, 1, "cfg flip b");

        // Seeded random frames
        for (int f = 0; f < 25; f++) begin
            int len;
            len = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 2032))
                                              : int'($urandom_range(0, 120));
            run_frame(len, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule